// File: doc/BRIEF.md
# Differential Third-Order Multilevel Noise Shaper

This block converts a stream of 24-bit two's-complement audio samples into two 31-level codes per shaper step, one from each of two matched third-order noise-shaping modulators. A sample arrives with a one-cycle strobe. It is then held and fed to both modulators for n consecutive steps, so the shaper runs at n times the sample rate. The integer n is a runtime input. The first modulator sees the sample as given. The second sees its negation. The two code streams therefore form a complementary pair that drives a differential pair of multilevel converters further down the chain.

Each modulator uses a third-order error-feedback loop. The quantizer error is fed back through the filter 3z^-1 - 3z^-2 + z^-3, which shapes the error by (1 - z^-1)^3. The loop works in a domain scaled by 15, so that every quantizer level lands on an exact multiple of 2^23. The sum path carries guard bits above the input width. The stored errors saturate at half a quantizer step, which keeps the loop bounded after clipping.

Top module: `dsm_diff_shaper`

## Requirements
- R1: While reset is low, and after reset until the first step, both level outputs read 15 and `lvl_vld` is 0. All loop state is cleared, so the first code after reset depends only on that sample.
- R2: Codes range from 0 to 30, with 15 as mid-scale. With cleared state, a sample x gives the code 15 + floor((15·x + 2^22) / 2^23), clipped to 0..30. This is the nearest level, with ties rounding up.
- R3: Path B processes the two's-complement negation of the sample. The most negative input (-2^23) negates to +2^23-1, so its first code after reset is 0 on A and 30 on B.
- R4: A sample strobed at clock edge E produces its first codes, with `lvl_vld` high, right after edge E+1. This is well within two sample periods.
- R5: Each strobe causes exactly n shaper steps, and `lvl_vld` is high for exactly n cycles, where n = `osr_n`. An `osr_n` of 0 acts as 1. A strobe that arrives during a burst loads the new sample and restarts the count of n.
- R6: In a cycle without a step, `lvl_vld` is 0 and both codes keep their last values.
- R7: For any window of W steps with a constant input |x| ≤ 2^22, the sum of the A codes is within 5 of W·(15 + 15·x/2^23). The sum of the B codes meets the same bound with -x.
- R8: Over such a window, the sum of A + B codes is within 10 of 30·W.
- R9: The stored loop errors never exceed half a quantizer step. Under a sustained input of +2^23-1, every A code is at least 26 and every B code is at most 4. After a return to a moderate input, R7 holds again from the first new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shaper clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle strobe: `smp_in` holds a new sample |
| smp_in | input | 24 | Two's-complement input sample |
| osr_n | input | 6 | Steps per sample (n); 0 behaves as 1 |
| lvl_a | output | 5 | In-phase level code, 0..30 |
| lvl_b | output | 5 | Inverted-phase level code, 0..30 |
| lvl_vld | output | 1 | High in the cycle after each shaper step |

## Verification
The hardest state to reach from the ports is the clamp of the stored loop errors. It occurs only when the quantizer clips, which needs a near-full-scale input held for many steps. The stimulus therefore holds +2^23-1 for hundreds of steps and checks the bounds on both code streams. It then drops to a moderate level and checks that the window average is accurate at once, which shows that no stale state wrapped or remained. Random DC levels at random n, together with directed strobe timings, cover the hold counter, burst restart and latency.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   localparam int DSM_IN_W   = 24;
   localparam int DSM_LEVELS = 31;
   localparam int DSM_GUARD  = 8;
   localparam int DSM_OSR_W  = 6;

   typedef enum logic {
      DSM_INPHASE = 1'b0,
      DSM_INVERT  = 1'b1
   } dsm_path_e;
endpackage

// File: rtl/dsm_zoh_hold.sv
module dsm_zoh_hold #(
   parameter int IN_W  = 24,
   parameter int OSR_W = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   stb_i,
   input  logic signed [IN_W-1:0] smp_i,
   input  logic [OSR_W-1:0]       osr_i,
   output logic signed [IN_W-1:0] smp_o,
   output logic                   step_o
);
   logic [OSR_W-1:0] cnt_q;
   logic [OSR_W-1:0] load_v;

   if (OSR_W < 1) begin : g_bad_osr
      $error("OSR_W must be at least 1");
   end

   assign load_v = (osr_i == '0) ? OSR_W'(1) : osr_i;
   assign step_o = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         smp_o <= '0;
      end else if (stb_i) begin
         cnt_q <= load_v;
         smp_o <= smp_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R5
   load_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> (cnt_q != '0));

   // R5
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_i && cnt_q != '0) |=> (cnt_q == OSR_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/dsm_efb3_mod.sv
module dsm_efb3_mod #(
   parameter int IN_W   = 24,
   parameter int LEVELS = 31,
   parameter int GUARD  = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             step_i,
   input  logic signed [IN_W-1:0]           smp_i,
   output logic [$clog2(LEVELS)-1:0]        lvl_o
);
   localparam int HALF_LV = (LEVELS - 1) / 2;
   localparam int CODE_W  = $clog2(LEVELS);
   localparam int SHIFT   = IN_W - 1;
   localparam int STATE_W = IN_W + GUARD;
   localparam int SUM_W   = STATE_W + 4;

   localparam logic signed [SUM_W-1:0]   LV_MUL   = SUM_W'(HALF_LV);
   localparam logic signed [SUM_W-1:0]   LIM_HI   = SUM_W'(HALF_LV);
   localparam logic signed [SUM_W-1:0]   LIM_LO   = -LIM_HI;
   localparam logic signed [SUM_W-1:0]   HSTEP    = SUM_W'(1) <<< (SHIFT - 1);
   localparam logic signed [SUM_W-1:0]   NHSTEP   = -HSTEP;
   localparam logic signed [STATE_W-1:0] HSTEP_ST = STATE_W'(1) <<< (SHIFT - 1);

   if (LEVELS < 3 || (LEVELS % 2) == 0) begin : g_bad_levels
      $error("LEVELS must be odd and at least 3");
   end
   if (GUARD < 8) begin : g_bad_guard
      $error("GUARD must be at least 8 bits");
   end

   logic signed [STATE_W-1:0] q1_q, q2_q, q3_q;
   logic signed [SUM_W-1:0]   xs, e1, e2, e3, fb, u, rnd, kq, yr, qr, qc;
   logic [CODE_W-1:0]         code_n;

   always_comb begin
      e1  = SUM_W'(q1_q);
      e2  = SUM_W'(q2_q);
      e3  = SUM_W'(q3_q);
      xs  = SUM_W'(smp_i) * LV_MUL;
      fb  = (e1 <<< 1) + e1 - ((e2 <<< 1) + e2) + e3;
      u   = xs - fb;
      rnd = (u + HSTEP) >>> SHIFT;
      if (rnd > LIM_HI)      kq = LIM_HI;
      else if (rnd < LIM_LO) kq = LIM_LO;
      else                   kq = rnd;
      yr  = kq <<< SHIFT;
      qr  = yr - u;
      if (qr > HSTEP)        qc = HSTEP;
      else if (qr < NHSTEP)  qc = NHSTEP;
      else                   qc = qr;
      code_n = CODE_W'(kq + LIM_HI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q1_q  <= '0;
         q2_q  <= '0;
         q3_q  <= '0;
         lvl_o <= CODE_W'(HALF_LV);
      end else if (step_i) begin
         q1_q  <= STATE_W'(qc);
         q2_q  <= q1_q;
         q3_q  <= q2_q;
         lvl_o <= code_n;
      end
   end

   // R2
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_o <= CODE_W'(LEVELS - 1));

   // R9
   err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q1_q <= HSTEP_ST) && (q1_q >= -HSTEP_ST) &&
      (q3_q <= HSTEP_ST) && (q3_q >= -HSTEP_ST));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(lvl_o) && $stable(q1_q));
endmodule

// File: rtl/dsm_diff_shaper.sv
module dsm_diff_shaper
   import dsm_pkg::*;
#(
   parameter int IN_W   = DSM_IN_W,
   parameter int LEVELS = DSM_LEVELS,
   parameter int GUARD  = DSM_GUARD,
   parameter int OSR_W  = DSM_OSR_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      smp_stb,
   input  logic [IN_W-1:0]           smp_in,
   input  logic [OSR_W-1:0]          osr_n,
   output logic [$clog2(LEVELS)-1:0] lvl_a,
   output logic [$clog2(LEVELS)-1:0] lvl_b,
   output logic                      lvl_vld
);
   localparam int CODE_W = $clog2(LEVELS);
   localparam logic signed [IN_W-1:0] SMP_MIN = {1'b1, {(IN_W-1){1'b0}}};
   localparam logic signed [IN_W-1:0] SMP_MAX = {1'b0, {(IN_W-1){1'b1}}};

   logic signed [IN_W-1:0] held_smp;
   logic                   step_en;
   logic [CODE_W-1:0]      lvl_w [2];

   dsm_zoh_hold #(.IN_W(IN_W), .OSR_W(OSR_W)) hold_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  (smp_stb),
      .smp_i  (smp_in),
      .osr_i  (osr_n),
      .smp_o  (held_smp),
      .step_o (step_en)
   );

   for (genvar g = 0; g < 2; g++) begin : g_path
      localparam dsm_path_e PATH = (g == 0) ? DSM_INPHASE : DSM_INVERT;
      logic signed [IN_W-1:0] path_smp;
      if (PATH == DSM_INVERT) begin : g_neg
         assign path_smp = (held_smp == SMP_MIN) ? SMP_MAX : -held_smp;
      end else begin : g_pos
         assign path_smp = held_smp;
      end
      dsm_efb3_mod #(.IN_W(IN_W), .LEVELS(LEVELS), .GUARD(GUARD)) mod_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .step_i (step_en),
         .smp_i  (path_smp),
         .lvl_o  (lvl_w[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_vld <= 1'b0;
      else        lvl_vld <= step_en;
   end

   assign lvl_a = lvl_w[0];
   assign lvl_b = lvl_w[1];

   // R6
   no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> (!lvl_vld && $stable(lvl_a) && $stable(lvl_b)));

   // R4
   stb_to_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> ##1 lvl_vld);
endmodule

// File: tb/dsm_diff_shaper_tb_top.sv
module dsm_diff_shaper_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0;
   logic [23:0] smp = '0;
   logic [5:0]  osr = 6'd8;
   logic [4:0]  lvl_a, lvl_b;
   logic        vld;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   dsm_diff_shaper dut_i (
      .clk(clk), .rst_n(rst_n), .smp_stb(stb), .smp_in(smp), .osr_n(osr),
      .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_vld(vld)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint negsat(input longint x);
      return (x == -64'sd8388608) ? 64'sd8388607 : -x;
   endfunction

   function automatic longint exp_code(input longint x);
      longint k;
      k = (15 * x + 64'sd4194304) >>> 23;
      if (k > 15) k = 15;
      if (k < -15) k = -15;
      return k + 15;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; stb = 1'b0;
      repeat (2) @(negedge clk);
      // R1: reset state
      chk(lvl_a == 5'd15, "R1 lvl_a in reset", lvl_a, 15);
      chk(lvl_b == 5'd15, "R1 lvl_b in reset", lvl_b, 15);
      chk(vld == 1'b0, "R1 vld in reset", vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R2 R3 R4: first codes after reset
   task automatic first_code(input longint x, input int n);
      do_reset();
      osr = 6'(n); smp = 24'(x); stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      chk(vld == 1'b0, "R4 vld one cycle after strobe", vld, 0);
      @(negedge clk);
      chk(vld == 1'b1, "R4 vld two cycles after strobe", vld, 1);
      chk(lvl_a == 5'(exp_code(x)), "R2 first A code", lvl_a, exp_code(x));
      chk(lvl_b == 5'(exp_code(negsat(x))), "R3 first B code", lvl_b, exp_code(negsat(x)));
      repeat (n + 2) @(negedge clk);
   endtask

   task automatic run_dc(input longint x, input int n, input int settle, input int win,
                         output longint sa, output longint sb, output int mina, output int maxb);
      int vc;
      int c;
      vc = 0; c = 0; sa = 0; sb = 0; mina = 99; maxb = -1;
      osr = 6'(n); smp = 24'(x);
      while (vc < settle + win) begin
         @(negedge clk);
         if (vld) begin
            vc++;
            if (vc > settle) begin
               sa += lvl_a; sb += lvl_b;
               if (int'(lvl_a) < mina) mina = int'(lvl_a);
               if (int'(lvl_b) > maxb) maxb = int'(lvl_b);
            end
         end
         stb = ((c % n) == 0);
         c++;
      end
      stb = 1'b0;
      repeat (n + 3) @(negedge clk);
   endtask

   task automatic dc_check(input longint x, input int n);
      longint sa, sb;
      int mina, maxb;
      real ea, eb;
      run_dc(x, n, 8, 256, sa, sb, mina, maxb);
      ea = 256.0 * (15.0 + 15.0 * real'(x) / 8388608.0);
      eb = 256.0 * (15.0 - 15.0 * real'(x) / 8388608.0);
      // R7
      chk((real'(sa) - ea <= 5.0) && (ea - real'(sa) <= 5.0), "R7 A window sum", sa, longint'(ea));
      chk((real'(sb) - eb <= 5.0) && (eb - real'(sb) <= 5.0), "R7 B window sum", sb, longint'(eb));
      // R8
      chk((sa + sb >= 7670) && (sa + sb <= 7690), "R8 A+B window sum", sa + sb, 7680);
   endtask

   task automatic count_vld(input int n, input int gap, output int cnt);
      cnt = 0;
      osr = 6'(n); smp = 24'sd1000; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      for (int i = 1; i < 40; i++) begin
         if (gap > 0 && i == gap) stb = 1'b1;
         @(negedge clk);
         stb = 1'b0;
         if (vld) cnt++;
      end
   endtask

   initial begin
      longint sa, sb;
      int mina, maxb, cnt;
      logic [4:0] la, lb;
      void'($urandom(32'd5865));
      do_reset();

      // R2 R3 R4 directed
      first_code(0, 8);
      first_code(-64'sd8388608, 4);
      first_code(64'sd8388607, 4);
      first_code(64'sd4194304, 3);
      for (int i = 0; i < 6; i++) begin
         longint x;
         int n;
         x = longint'($urandom_range(8388608, 0)) - 64'sd4194304;
         n = int'($urandom_range(12, 1));
         first_code(x, n);
         dc_check(x, n);
      end

      // R7 R8 directed levels
      do_reset();
      dc_check(0, 8);
      dc_check(64'sd4194304, 1);
      dc_check(-64'sd4194304, 16);

      // R5 step counts
      do_reset();
      count_vld(5, 0, cnt);
      chk(cnt == 5, "R5 steps for n=5", cnt, 5);
      count_vld(0, 0, cnt);
      chk(cnt == 1, "R5 steps for n=0", cnt, 1);
      count_vld(4, 2, cnt);
      chk(cnt == 6, "R5 restart on early strobe", cnt, 6);

      // R6 outputs hold while idle
      la = lvl_a; lb = lvl_b;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(vld == 1'b0, "R6 vld idle", vld, 0);
         chk(lvl_a == la && lvl_b == lb, "R6 codes held", {lvl_a, lvl_b}, {la, lb});
      end

      // R9 sustained full scale, then recovery
      run_dc(64'sd8388607, 8, 0, 300, sa, sb, mina, maxb);
      chk(mina >= 26, "R9 min A at full scale", mina, 26);
      chk(maxb <= 4, "R9 max B at full scale", maxb, 4);
      dc_check(64'sd2097152, 8);

      // R1 reset after activity
      do_reset();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule